// File: doc/BRIEF.md
# Load-Enabled Hold Register with Output Validity

This block is a single storage stage for a W-bit data word. On every clock edge where the load bit is sampled high, the block captures the word on its data input. On edges where load is low, the stored word stays as it is. The stored word appears on the data output in the cycle after the capture edge, so the output always shows the data from the most recent cycle in which load was high.

From reset until the first capture, the block has no meaningful value to show. A valid flag reports this state and stays low. While the flag is low, the data output is forced to zero. A small two-state controller tracks whether anything has been captured yet. State EMPTY is entered by reset. Transition FILL goes from EMPTY to FULL on the first load. State FULL then persists through both of its self-transitions, RELOAD (load high) and KEEP (load low), until the next synchronous reset sends it back to EMPTY.

A typical use is to sample a value from a stream at marked instants and hold it for downstream logic. The valid flag tells that logic whether a sample exists yet.

Top module: `capture_hold_reg`

## Requirements
- R1: On a clock edge where rst is high, the block returns to EMPTY. In the following cycle valid_o is 0 and dout_o is all zeros.
- R2: On an edge where rst is low and load_i is high, the value on din_i is captured. In the next cycle dout_o equals that value and valid_o is 1.
- R3: On an edge where rst is low and load_i is low, dout_o and valid_o keep the values they had before that edge.
- R4: From reset until the first edge with load_i high, valid_o stays 0 and dout_o stays all zeros, whatever din_i carries.
- R5: valid_o rises only on an edge where load_i was sampled high. It falls only on an edge where rst was sampled high.
- R6: When load_i is high on consecutive edges, each capture replaces the previous one, and dout_o follows din_i with a one-cycle delay.
- R7: When rst and load_i are both high on the same edge, reset wins. Nothing is captured and valid_o is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture enable for din_i |
| din_i | input | W | Data word to capture |
| dout_o | output | W | Held word, zero while invalid |
| valid_o | output | 1 | High once a word has been captured since reset |

## Verification
Two functions can fall on the same edge: reset and a capture. The bench provokes this by raising rst and load_i together. It does so both while the block is in FULL holding a nonzero word and while it is in EMPTY. It then judges that the next cycle shows valid_o low and dout_o zero. The first capture after reset coincides with the FILL transition. The bench checks that valid_o and the captured word appear together in one cycle, never one ahead of the other.

// File: rtl/chr_pkg.sv
package chr_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } chr_state_e;
endpackage

// File: rtl/chr_ctrl.sv
module chr_ctrl
    import chr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic full_o
);
    chr_state_e state_q;
    chr_state_e state_d;

    // next-state logic: FILL (EMPTY->FULL), RELOAD and KEEP (FULL->FULL)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (load_i) state_d = ST_FULL;
            ST_FULL:  state_d = ST_FULL;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        full_o = (state_q == ST_FULL);
    end
endmodule

// File: rtl/chr_store.sv
module chr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)         word_q <= '0;
        else if (load_i) word_q <= din_i;
    end

    assign word_o = word_q;
endmodule

// File: rtl/capture_hold_reg.sv
module capture_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output logic         valid_o
);
    localparam logic [W-1:0] ZERO_WORD = '0;

    logic         full;
    logic [W-1:0] held;

    chr_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .full_o (full)
    );

    chr_store #(.W(W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .din_i  (din_i),
        .word_o (held)
    );

    // output process: mask the word while nothing has been captured
    always_comb begin
        valid_o = full;
        dout_o  = full ? held : ZERO_WORD;
    end
endmodule

// File: rtl/capture_hold_reg_chk.sv
module capture_hold_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load_i,
    input logic [W-1:0] din_i,
    input logic [W-1:0] dout_o,
    input logic         valid_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!valid_o && dout_o == '0));

    assert_load_captures_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (valid_o && dout_o == $past(din_i)));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(dout_o) && $stable(valid_o)));

    assert_valid_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(load_i));

    assert_valid_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(valid_o) |-> $past(rst));
endmodule

bind capture_hold_reg capture_hold_reg_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .din_i   (din_i),
    .dout_o  (dout_o),
    .valid_o (valid_o)
);

// File: tb/capture_hold_reg_tb.sv
module capture_hold_reg_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [W-1:0] din_i = '0;
    logic [W-1:0] dout_o;
    logic         valid_o;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    int  ref_valid = 0;
    int  ref_word  = 0;

    always #2 clk = ~clk;

    capture_hold_reg #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .load_i(load_i),
        .din_i(din_i), .dout_o(dout_o), .valid_o(valid_o)
    );

    task automatic compare(input string tag);
        int exp_d;
        exp_d = ref_valid ? ref_word : 0;
        n_checks++;
        if (valid_o !== ref_valid[0] || int'(dout_o) != exp_d || $isunknown(dout_o)) begin
            n_fail++;
            $display("FAIL %s: valid=%0d dout=%0d expected valid=%0d dout=%0d",
                     tag, valid_o, dout_o, ref_valid, exp_d);
        end
    endtask

    // drive on falling edge, update model at rising edge, sample 1 ns later
    task automatic step(input logic r, input logic ld, input int d, input string tag);
        @(negedge clk);
        rst = r; load_i = ld; din_i = W'(d);
        @(posedge clk);
        if (r) begin
            ref_valid = 0; ref_word = 0;
        end else if (ld) begin
            ref_valid = 1; ref_word = d;
        end
        #1;
        compare(tag);
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(1, 0, 0, "R1 reset state");
        step(1, 0, 0, "R1 reset held");
        // example trace: data 0..4, load F,F,T,F,T
        step(0, 0, 0, "R4 cycle0 invalid");
        step(0, 0, 1, "R4 cycle1 invalid");
        step(0, 1, 2, "R2 R5 first capture of 2");
        step(0, 0, 3, "R3 hold 2");
        step(0, 1, 4, "R2 capture of 4");
        step(0, 0, 9, "R3 hold 4");
        // back-to-back loads
        for (int i = 0; i < 6; i++) step(0, 1, 8'hA0 + i, "R6 consecutive loads");
        for (int i = 0; i < 4; i++) step(0, 0, 8'h11 * i, "R3 idle with changing din");
        // reset and load together while FULL
        step(1, 1, 8'h77, "R7 reset beats load when full");
        for (int i = 0; i < 3; i++) step(0, 0, 8'hFF, "R4 invalid until load");
        step(0, 1, 8'hFF, "R2 capture all ones");
        // reset and load together while EMPTY
        step(1, 0, 0, "R1 reset again");
        step(1, 1, 8'h3C, "R7 reset beats load when empty");
        step(0, 0, 8'h3C, "R4 still invalid");
        step(0, 1, 0, "R2 R5 capture zero sets valid");
        step(0, 0, 8'h55, "R3 hold zero as valid");
        // mixed pattern
        for (int i = 0; i < 20; i++) step(0, (i % 3) == 1, 7 * i + 1, "R6 mixed loads");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule